// File: doc/BRIEF.md
# UART Receive Buffer Status Controller

This block sits between a UART receiver core and a software register interface. The receiver core hands it one byte at a time, each with framing, parity and noise qualifiers. The block keeps those bytes in one of two stores, chosen by a mode input. The first is a small message buffer that collects a programmed number of bytes and then waits for software. The second is a receive FIFO that a DMA engine drains through a pop port.

The block also keeps the receive status flags. These are buffer-ready, overrun, data-received (which reads as FIFO-empty in FIFO mode), framing error, noise, character timeout and wake-up. Software clears each flag by writing a 1 to it. An interrupt line ORs the enabled flags.

Overrun handling depends on the mode. In message-buffer mode a lock control chooses whether the late byte is discarded or overwrites the buffer. In FIFO mode the late byte is always dropped.

Top module: `uart_rx_status`

## Requirements
- R1: In message-buffer mode (`fifo_mode`=0), accepted bytes are written to buffer slots 0, 1, 2… in arrival order. The message length is `cfg_msg_len`+1 bytes. When the last byte of a message is written, status bit 0 (ready) and status bit 2 (data-received) are set. `rd_data` returns the slot selected by `rd_idx`.
- R2: In message-buffer mode, a byte that arrives while status bit 0 is set raises status bit 1 (overrun) and status bit 2.
- R3: On a message-buffer overrun with `lock_mode`=1, the byte is dropped and the buffer is left unchanged. With `lock_mode`=0, the byte is written at the next slot, exactly as an ordinary write.
- R4: In FIFO mode (`fifo_mode`=1), accepted bytes enter a FIFO of `FIFO_DEPTH` entries. A byte that arrives while the FIFO is full sets status bit 1 and is dropped, whatever `lock_mode` says. `rd_data` shows the oldest entry, and `fifo_pop` removes it.
- R5: In FIFO mode, status bit 2 reads the live FIFO-empty condition instead of the data-received flag.
- R6: An accepted byte with a framing error sets status bit 3. A byte with noise sets status bit 4. In message-buffer mode, a framing or parity error also sets status bit 2.
- R7: A 1 in bit i of `flag_clr` (i = 0..6) clears status flag i. A hardware set of that flag in the same cycle wins over the clear.
- R8: When `tmo_preset` is non-zero, each accepted byte restarts a counter at 0. The counter then advances once per clock. Status bit 5 is set on the clock at which it becomes equal to `tmo_preset`, and the counter stops there.
- R9: A falling edge on `rx_pin` (1 in one cycle, 0 in the next) while `sleep_mode`=1 sets status bit 6 one clock later. Without `sleep_mode` the edge does nothing.
- R10: While `init_mode`=1, status bits 0 and 6 are held at 0. In the same mode, incoming bytes are ignored, the buffer slot index returns to 0 and the FIFO is emptied.
- R11: `irq` is the OR of status bits 0..6 ANDed with `irq_en`, with bit 2 excluded in FIFO mode. Status bit 7 mirrors `rx_pin`.
- R12: After reset, all flags are 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_mode | input | 1 | Controller in initialization mode |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects message-buffer mode |
| lock_mode | input | 1 | Buffer-mode overrun policy: 1 discard, 0 overwrite |
| cfg_msg_len | input | 2 | Message length minus one (buffer mode) |
| tmo_preset | input | 8 | Character timeout value, 0 disables |
| rx_valid | input | 1 | Received byte strobe from receiver core |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | Byte had an invalid stop bit |
| rx_parity_err | input | 1 | Byte had a parity error |
| rx_noise | input | 1 | Noise seen on the byte |
| sleep_mode | input | 1 | Controller asleep |
| rx_pin | input | 1 | Receive pin level, already synchronized |
| flag_clr | input | 7 | Write-1-to-clear strobes for status bits 0..6 |
| irq_en | input | 7 | Interrupt enables for status bits 0..6 |
| rd_idx | input | 2 | Buffer slot to read in buffer mode |
| fifo_pop | input | 1 | DMA read strobe, removes the FIFO head |
| rd_data | output | 8 | Selected buffer slot or FIFO head |
| status | output | 8 | Flags: 0 ready, 1 overrun, 2 data-received/empty, 3 framing, 4 noise, 5 timeout, 6 wake-up, 7 pin |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters is a software clear landing in the same cycle as a hardware set. The bench arranges this by sending a byte while the buffer is already ready and overwrite mode is on, and by writing all seven clear bits in that same cycle. That byte raises overrun, data-received and, because it completes a message, ready. The status word read one clock later must show exactly those three bits set and every other flag cleared.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;
  localparam int FLAG_W   = 7;
  localparam int FL_READY = 0;
  localparam int FL_OVR   = 1;
  localparam int FL_DRX   = 2;
  localparam int FL_FERR  = 3;
  localparam int FL_NOISE = 4;
  localparam int FL_TMO   = 5;
  localparam int FL_WAKE  = 6;

  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push)
        wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
      if (do_pop)
        rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  // R4
  fifo_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R4
  fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (full && $stable(wr_ptr_q)));
endmodule

// File: rtl/rxs_msgbuf.sv
module rxs_msgbuf #(
  parameter int NBYTES = 4,
  parameter int W      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      wr_en,
  input  logic [W-1:0]              din,
  input  logic [$clog2(NBYTES)-1:0] last_idx,
  input  logic [$clog2(NBYTES)-1:0] rd_idx,
  output logic [W-1:0]              dout,
  output logic                      done
);
  localparam int IW = $clog2(NBYTES);

  logic [W-1:0]  slots [NBYTES];
  logic [IW-1:0] idx_q, idx_d;
  logic          wr_ok;

  assign wr_ok = wr_en && !flush;
  assign done  = wr_ok && (idx_q == last_idx);
  assign dout  = slots[rd_idx];

  always_comb begin
    idx_d = idx_q;
    if (flush)      idx_d = '0;
    else if (wr_ok) idx_d = done ? '0 : idx_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) slots[idx_q] <= din;
  end

  // R3
  msg_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !flush) |=> $stable(idx_q));

  // R1
  msg_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (idx_q == '0));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rxs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int MSG_BYTES  = 4,
  parameter int TMO_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         init_mode,
  input  logic                         fifo_mode,
  input  logic                         lock_mode,
  input  logic [$clog2(MSG_BYTES)-1:0] cfg_msg_len,
  input  logic [TMO_W-1:0]             tmo_preset,
  input  logic                         rx_valid,
  input  logic [DATA_W-1:0]            rx_data,
  input  logic                         rx_frame_err,
  input  logic                         rx_parity_err,
  input  logic                         rx_noise,
  input  logic                         sleep_mode,
  input  logic                         rx_pin,
  input  logic [FLAG_W-1:0]            flag_clr,
  input  logic [FLAG_W-1:0]            irq_en,
  input  logic [$clog2(MSG_BYTES)-1:0] rd_idx,
  input  logic                         fifo_pop,
  output logic [DATA_W-1:0]            rd_data,
  output logic [FLAG_W:0]              status,
  output logic                         irq
);
  flag_vec_t        flag_q, flag_d, flag_set;
  flag_vec_t        shown, irq_mask;
  logic             accept, buf_over, buf_wr, buf_done;
  logic             fifo_push, fifo_over, fifo_empty, fifo_full;
  logic [DATA_W-1:0] buf_dout, fifo_dout;
  logic             pin_q;
  logic             wake_edge;
  logic             tmo_run_q, tmo_run_d, tmo_hit;
  logic [TMO_W-1:0] tmo_cnt_q, tmo_cnt_d;

  assign accept    = rx_valid && !init_mode;
  assign buf_over  = accept && !fifo_mode && flag_q[FL_READY];
  assign buf_wr    = accept && !fifo_mode && (!flag_q[FL_READY] || !lock_mode);
  assign fifo_over = accept && fifo_mode && fifo_full;
  assign fifo_push = accept && fifo_mode;

  rxs_msgbuf #(.NBYTES(MSG_BYTES), .W(DATA_W)) u_msgbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (init_mode),
    .wr_en    (buf_wr),
    .din      (rx_data),
    .last_idx (cfg_msg_len),
    .rd_idx   (rd_idx),
    .dout     (buf_dout),
    .done     (buf_done)
  );

  rxs_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (init_mode),
    .push  (fifo_push),
    .din   (rx_data),
    .pop   (fifo_pop && fifo_mode),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  // character timeout counter
  always_comb begin
    tmo_run_d = tmo_run_q;
    tmo_cnt_d = tmo_cnt_q;
    tmo_hit   = 1'b0;
    if (init_mode) begin
      tmo_run_d = 1'b0;
      tmo_cnt_d = '0;
    end else if (accept) begin
      tmo_run_d = (tmo_preset != '0);
      tmo_cnt_d = '0;
    end else if (tmo_run_q) begin
      tmo_cnt_d = tmo_cnt_q + TMO_W'(1);
      if (tmo_cnt_d == tmo_preset) begin
        tmo_hit   = 1'b1;
        tmo_run_d = 1'b0;
      end
    end
  end

  assign wake_edge = sleep_mode && !init_mode && pin_q && !rx_pin;

  always_comb begin
    flag_set            = '0;
    flag_set[FL_READY]  = buf_done;
    flag_set[FL_OVR]    = buf_over || fifo_over;
    flag_set[FL_DRX]    = accept && !fifo_mode &&
                          (buf_done || buf_over || rx_frame_err || rx_parity_err);
    flag_set[FL_FERR]   = accept && rx_frame_err;
    flag_set[FL_NOISE]  = accept && rx_noise;
    flag_set[FL_TMO]    = tmo_hit;
    flag_set[FL_WAKE]   = wake_edge;
  end

  always_comb begin
    flag_d = flag_set | (flag_q & ~flag_clr);
    if (init_mode) begin
      flag_d[FL_READY] = 1'b0;
      flag_d[FL_WAKE]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= '0;
      pin_q     <= 1'b1;
      tmo_run_q <= 1'b0;
      tmo_cnt_q <= '0;
    end else begin
      flag_q    <= flag_d;
      pin_q     <= rx_pin;
      tmo_run_q <= tmo_run_d;
      tmo_cnt_q <= tmo_cnt_d;
    end
  end

  always_comb begin
    shown         = flag_q;
    shown[FL_DRX] = fifo_mode ? fifo_empty : flag_q[FL_DRX];
    irq_mask      = irq_en;
    if (fifo_mode) irq_mask[FL_DRX] = 1'b0;
  end

  assign status  = {rx_pin, shown};
  assign irq     = |(shown & irq_mask);
  assign rd_data = fifo_mode ? fifo_dout : buf_dout;

  // R7
  ovr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[FL_OVR] |=> flag_q[FL_OVR]);

  // R10
  init_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |=> (!flag_q[FL_READY] && !flag_q[FL_WAKE]));

  // R8
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_run_q |-> (tmo_cnt_q < tmo_preset));

  // R9
  wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_mode && !init_mode && pin_q && !rx_pin) |=> flag_q[FL_WAKE]);

  // R4
  fifo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && fifo_full && rx_valid && !init_mode) |=> flag_q[FL_OVR]);
endmodule

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       v;
    logic [7:0] d;
    logic       fe;
    logic       pe;
    logic       nz;
    logic [6:0] clr;
    logic [6:0] exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00},
    '{1'b1, 8'hB2, 1'b0, 1'b0, 1'b0, 7'h00, 7'h05},
    '{1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 7'h00, 7'h07},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 7'h07, 7'h00},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00},
    '{1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 7'h00, 7'h0C},
    '{1'b1, 8'h6B, 1'b0, 1'b0, 1'b1, 7'h00, 7'h1D},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 7'h7F, 7'h00},
    '{1'b1, 8'h7C, 1'b0, 1'b1, 1'b0, 7'h00, 7'h04},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 7'h04, 7'h00}
  };

  logic       clk, rst_n;
  logic       init_mode, fifo_mode, lock_mode, sleep_mode, rx_pin;
  logic [1:0] cfg_msg_len, rd_idx;
  logic [7:0] tmo_preset, rx_data, rd_data;
  logic       rx_valid, rx_frame_err, rx_parity_err, rx_noise, fifo_pop, irq;
  logic [6:0] flag_clr, irq_en;
  logic [7:0] status;

  int tests = 0;
  int fails = 0;

  uart_rx_status dut (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .fifo_mode(fifo_mode),
    .lock_mode(lock_mode), .cfg_msg_len(cfg_msg_len), .tmo_preset(tmo_preset),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .rx_noise(rx_noise), .sleep_mode(sleep_mode),
    .rx_pin(rx_pin), .flag_clr(flag_clr), .irq_en(irq_en), .rd_idx(rd_idx),
    .fifo_pop(fifo_pop), .rd_data(rd_data), .status(status), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
    rx_noise = 1'b0; flag_clr = '0; fifo_pop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; init_mode = 1'b0; fifo_mode = 1'b0; lock_mode = 1'b1;
    sleep_mode = 1'b0; rx_pin = 1'b1; cfg_msg_len = 2'd1; rd_idx = '0;
    tmo_preset = '0; rx_data = '0; rx_valid = 1'b0; rx_frame_err = 1'b0;
    rx_parity_err = 1'b0; rx_noise = 1'b0; fifo_pop = 1'b0;
    flag_clr = '0; irq_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 reset status", status, 8'h80);
    chk("R12 reset irq", irq, 0);

    // table: buffer mode, 2-byte message, lock on (R1/R2/R3/R6/R7)
    for (int i = 0; i < NVEC; i++) begin
      rx_valid = VECS[i].v; rx_data = VECS[i].d; rx_frame_err = VECS[i].fe;
      rx_parity_err = VECS[i].pe; rx_noise = VECS[i].nz; flag_clr = VECS[i].clr;
      step();
      chk($sformatf("R1/R2/R6 vector %0d", i), status[6:0], VECS[i].exp);
    end
    rd_idx = 2'd0; #1;
    chk("R1 slot0", rd_data, 8'h7C);
    rd_idx = 2'd1; #1;
    chk("R3 slot1 kept under lock", rd_data, 8'h6B);

    // overwrite policy (R3)
    send(8'h11);
    lock_mode = 1'b0;
    send(8'h33);
    chk("R3 overwrite flags", status[2:0], 3'b111);
    rd_idx = 2'd0; #1;
    chk("R3 overwrite slot0", rd_data, 8'h33);
    rd_idx = 2'd1; #1;
    chk("R3 slot1 intact", rd_data, 8'h11);

    // clear vs hardware set in one cycle (R7)
    flag_clr = 7'h7F;
    send(8'h44);
    chk("R7 set beats clear", status[6:0], 7'h07);
    flag_clr = 7'h7F; step();
    chk("R7 clear all", status[6:0], 7'h00);

    // interrupt (R11)
    irq_en = 7'h02;
    send(8'h55);
    send(8'h66);
    chk("R11 irq masked ready", irq, 0);
    send(8'h77);
    chk("R11 irq on overrun", irq, 1);
    flag_clr = 7'h7F; irq_en = '0; step();

    // timeout (R8)
    tmo_preset = 8'd5;
    send(8'h88);
    repeat (4) @(negedge clk);
    chk("R8 timeout not yet", status[5], 0);
    @(negedge clk);
    chk("R8 timeout set", status[5], 1);
    flag_clr = 7'h7F; step();
    tmo_preset = '0;
    repeat (8) @(negedge clk);
    chk("R8 counter stopped", status[5], 0);

    // wake-up (R9)
    rx_pin = 1'b0; step();
    chk("R9 no wake awake", status[6], 0);
    chk("R11 pin mirror", status[7], 0);
    rx_pin = 1'b1; step();
    sleep_mode = 1'b1; rx_pin = 1'b0; step();
    chk("R9 wake set", status[6], 1);
    rx_pin = 1'b1; sleep_mode = 1'b0; step();

    // initialization mode (R10)
    send(8'h99);
    init_mode = 1'b1; step();
    chk("R10 ready/wake forced", {status[6], status[0]}, 2'b00);
    send(8'hEE);
    chk("R10 byte ignored", status[1], 0);
    fifo_mode = 1'b1; flag_clr = 7'h7F; step();
    init_mode = 1'b0; step();
    chk("R5 fifo empty after init", status, 8'h84);

    // FIFO mode (R4/R5)
    for (int k = 0; k < 4; k++) send(8'hC0 + 8'(k));
    chk("R5 not empty", status[2], 0);
    chk("R4 head", rd_data, 8'hC0);
    send(8'hC4);
    chk("R4 overrun when full", status[1], 1);
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R4 pop order %0d", k), rd_data, 8'hC0 + 8'(k));
      fifo_pop = 1'b1; step();
    end
    chk("R5 empty after drain", status[2], 1);
    irq_en = 7'h04; #1;
    chk("R11 empty not an irq", irq, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule